// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block receives characters from an asynchronous serial line. It takes a free-running oversampling enable (`baud_tick`, sixteen pulses per bit by default) from a rate generator outside the block. It synchronises the line and finds a start bit on a falling edge. It then samples each later bit at its centre and builds a 7-bit or 8-bit character, least significant bit first. The character may carry an even or odd parity bit, and the frame ends in one or two stop bits.

Each finished character goes into a data register. A small register port exposes a status word and that data register. The status word holds three sticky flags: data ready, parity error and framing error. A flag can be cleared only by reading it as 1 from the status address and then writing 0 to that bit. While either error flag is set the receiver ignores the line, so software must deal with the error before any more characters are taken.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, and in the cycle after `standby` is high, the status word (address 0) reads 0. Status bit 0 is data ready, bit 1 is parity error, bit 2 is framing error, and bits 7..3 read 0. After reset the data register (address 1) reads 0.
- R2: In 8-bit mode, a correctly framed character arrives least significant bit first. It appears at address 1, and status bit 0 becomes 1.
- R3: In 7-bit mode (`cfg_len7`=1), seven data bits are taken. The data register shows them in bits 6..0, with bit 7 at 0.
- R4: With parity on, the parity error flag sets when the number of 1s over the data bits and the parity bit is odd in even mode (`cfg_par_odd`=0), or even in odd mode.
- R5: The framing error flag sets when the first stop bit is sampled low. When two stop bits are configured, a low second stop bit causes no error.
- R6: A character that ends with a parity or framing error is still written to the data register, and data ready is not set by it.
- R7: While either error flag is 1, no new character is received: the data register and the status word stay unchanged.
- R8: A status flag clears only on a write of 0 to its bit at address 0 after a status read that returned that bit as 1. Any status write cancels pending reads. A write of 0 with no such read leaves the flag at 1.
- R9: While `rx_en` is 0 the error flags keep their values and no character is received.
- R10: A low pulse on the line that is high again at the middle of the start bit (the 8th oversample tick) is dropped as a glitch and leaves the status at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Low-power request; aborts reception and clears all flags |
| rx_en | input | 1 | Receive enable |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 expects a parity bit after the data |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| baud_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| reg_addr | input | 1 | 0 = status word, 1 = data register |
| reg_rd | input | 1 | Read strobe (arms flag clearing on the status address) |
| reg_wr | input | 1 | Write strobe (status address only) |
| reg_wdata | input | 3 | Write data for the status flags |
| reg_rdata | output | 8 | Read data for the selected address |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, a two-stage line synchroniser, and a rate enable that the bench pulses every fourth clock, so one bit lasts 64 clocks. With these values the mid-bit sample lands well inside each bit, and a 12-clock low pulse ends before the start-bit check. This makes the glitch rejection, the ignored second stop bit and the error stall each reachable in a frame of under a thousand clocks. Both parity senses and both character lengths are driven.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 8;
  localparam int STAT_W = 3;

  localparam int ST_FULL = 0;
  localparam int ST_PERR = 1;
  localparam int ST_FERR = 2;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

  // Keep the data bits that the current length uses.
  function automatic logic [DATA_W-1:0] mask_len(input logic [DATA_W-1:0] d,
                                                 input logic len7);
    logic [DATA_W-1:0] m;
    m = d;
    if (len7) m[DATA_W-1] = 1'b0;
    return m;
  endfunction

  // 1 when the received parity disagrees with the selected sense.
  function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                      input logic len7,
                                      input logic odd,
                                      input logic pbit);
    logic total_odd;
    total_odd = (^mask_len(d, len7)) ^ pbit;
    return odd ? ~total_odd : total_odd;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], din};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign dout = pipe_q[STAGES-1];
  assign fall = prev_q & ~pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              fall,
  input  logic              go_ok,
  input  logic              run_ok,
  input  logic              cfg_len7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              done_perr,
  output logic              done_ferr
);
  localparam int CW = $clog2(OS);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] data_q;
  logic              pbit_q;
  logic              at_mid;
  logic              at_end;
  logic [IW-1:0]     last_idx;

  assign at_mid   = tick && (cnt_q == MID);
  assign at_end   = tick && (cnt_q == LAST);
  assign last_idx = cfg_len7 ? IW'(DATA_W - 2) : IW'(DATA_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      pbit_q  <= 1'b0;
    end else if (!run_ok) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: begin
          if (fall && go_ok) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
        end
        RX_START: begin
          if (at_mid) begin
            cnt_q <= '0;
            if (rxd) begin
              state_q <= RX_IDLE;
            end else begin
              state_q <= RX_DATA;
              idx_q   <= '0;
              data_q  <= '0;
            end
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_end) begin
            cnt_q         <= '0;
            data_q[idx_q] <= rxd;
            if (idx_q == last_idx) state_q <= cfg_par_en ? RX_PAR : RX_STOP1;
            else                   idx_q   <= idx_q + 1'b1;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_end) begin
            cnt_q   <= '0;
            pbit_q  <= rxd;
            state_q <= RX_STOP1;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP1: begin
          if (at_end) begin
            cnt_q   <= '0;
            state_q <= cfg_two_stop ? RX_STOP2 : RX_IDLE;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP2: begin
          if (at_end) begin
            cnt_q   <= '0;
            state_q <= RX_IDLE;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done      = run_ok && (state_q == RX_STOP1) && at_end;
  assign done_data = data_q;
  assign done_ferr = ~rxd;
  assign done_perr = cfg_par_en && parity_bad(data_q, cfg_len7, cfg_par_odd, pbit_q);
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  input  logic              done_perr,
  input  logic              done_ferr,
  input  logic              reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [STAT_W-1:0] flags,
  output logic [STAT_W-1:0] armed,
  output logic [DATA_W-1:0] rdr
);
  logic [STAT_W-1:0] flags_q;
  logic [STAT_W-1:0] arm_q;
  logic [DATA_W-1:0] rdr_q;
  logic [STAT_W-1:0] set_v;
  logic [STAT_W-1:0] clr_v;
  logic              rd_stat;
  logic              wr_stat;

  assign rd_stat = reg_rd && !reg_addr;
  assign wr_stat = reg_wr && !reg_addr;

  always_comb begin
    set_v          = '0;
    set_v[ST_FULL] = done && !done_perr && !done_ferr;
    set_v[ST_PERR] = done && done_perr;
    set_v[ST_FERR] = done && done_ferr;
  end

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_flag
      assign clr_v[gi] = wr_stat && arm_q[gi] && !reg_wdata[gi];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flags_q[gi] <= 1'b0;
          arm_q[gi]   <= 1'b0;
        end else if (standby) begin
          flags_q[gi] <= 1'b0;
          arm_q[gi]   <= 1'b0;
        end else begin
          flags_q[gi] <= set_v[gi] | (flags_q[gi] & ~clr_v[gi]);
          if (wr_stat)      arm_q[gi] <= 1'b0;
          else if (rd_stat) arm_q[gi] <= arm_q[gi] | flags_q[gi];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdr_q <= '0;
    else if (done) rdr_q <= done_data;
  end

  assign reg_rdata = reg_addr ? rdr_q : {{(DATA_W-STAT_W){1'b0}}, flags_q};
  assign flags     = flags_q;
  assign armed     = arm_q;
  assign rdr       = rdr_q;
endmodule

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky
  import uart_rx_pkg::*;
#(
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              rx_en,
  input  logic              cfg_len7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic              line_s;
  logic              line_fall;
  logic              done_evt;
  logic [DATA_W-1:0] done_data;
  logic              done_perr;
  logic              done_ferr;
  logic [STAT_W-1:0] flags;
  logic [STAT_W-1:0] armed;
  logic [DATA_W-1:0] rdr;
  logic              st_full;
  logic              st_perr;
  logic              st_ferr;
  logic              arm_ferr;
  logic              stall;
  logic              run_ok;
  logic              go_ok;

  assign st_full  = flags[ST_FULL];
  assign st_perr  = flags[ST_PERR];
  assign st_ferr  = flags[ST_FERR];
  assign arm_ferr = armed[ST_FERR];
  assign stall    = st_perr | st_ferr;
  assign run_ok   = rx_en & ~standby;
  assign go_ok    = run_ok & ~stall;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s),
    .fall (line_fall)
  );

  uart_rx_engine #(.OS(OS)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (baud_tick),
    .rxd         (line_s),
    .fall        (line_fall),
    .go_ok       (go_ok),
    .run_ok      (run_ok),
    .cfg_len7    (cfg_len7),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_two_stop(cfg_two_stop),
    .done        (done_evt),
    .done_data   (done_data),
    .done_perr   (done_perr),
    .done_ferr   (done_ferr)
  );

  uart_rx_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .done     (done_evt),
    .done_data(done_data),
    .done_perr(done_perr),
    .done_ferr(done_ferr),
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .flags    (flags),
    .armed    (armed),
    .rdr      (rdr)
  );
endmodule

// File: rtl/uart_rx_sticky_chk.sv
module uart_rx_sticky_chk
  import uart_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              rx_en,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic              done_evt,
  input logic              done_perr,
  input logic              done_ferr,
  input logic [DATA_W-1:0] done_data,
  input logic              st_full,
  input logic              st_perr,
  input logic              st_ferr,
  input logic              arm_ferr,
  input logic [DATA_W-1:0] rdr
);
  a_r1_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (!st_full && !st_perr && !st_ferr));

  a_r4_parity_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && done_perr) |=> st_perr);

  a_r5_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && done_ferr) |=> st_ferr);

  a_r6_err_no_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && (done_perr || done_ferr) && !st_full) |=> !st_full);

  a_r6_data_stored: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (rdr == $past(done_data)));

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_perr || st_ferr) |-> !done_evt);

  a_r8_unarmed_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && !arm_ferr && st_ferr && !standby) |=> st_ferr);

  a_r9_rx_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !standby && !reg_wr) |=> ($stable(st_perr) && $stable(st_ferr)));
endmodule

bind uart_rx_sticky uart_rx_sticky_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .standby  (standby),
  .rx_en    (rx_en),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .done_evt (done_evt),
  .done_perr(done_perr),
  .done_ferr(done_ferr),
  .done_data(done_data),
  .st_full  (st_full),
  .st_perr  (st_perr),
  .st_ferr  (st_ferr),
  .arm_ferr (arm_ferr),
  .rdr      (rdr)
);

// File: tb/uart_rx_sticky_test.sv
`timescale 1ns/100ps
module uart_rx_sticky_test;
  localparam int BIT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic       rx_en = 1'b0;
  logic       cfg_len7 = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       reg_addr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] tdiv = '0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tdiv      <= tdiv + 1'b1;
    baud_tick <= (tdiv == 2'd3);
  end

  uart_rx_sticky uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .rx_en(rx_en),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .baud_tick(baud_tick), .rxd(rxd),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] d);
    @(negedge clk);
    reg_addr  = 1'b0;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic hold(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic len7, input logic odd);
    int ones = 0;
    for (int i = 0; i < (len7 ? 7 : 8); i++) ones += d[i];
    return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  task automatic send(input logic [7:0] d, input logic pflip,
                      input logic stop1, input logic stop2);
    @(negedge clk);
    hold(1'b0, BIT);
    for (int i = 0; i < (cfg_len7 ? 7 : 8); i++) hold(d[i], BIT);
    if (cfg_par_en) hold(par_of(d, cfg_len7, cfg_par_odd) ^ pflip, BIT);
    hold(stop1, BIT);
    if (cfg_two_stop) hold(stop2, BIT);
    hold(1'b1, 2 * BIT);
  endtask

  task automatic clear_all();
    logic [7:0] v;
    rd(1'b0, v);
    wr(3'b000);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b0, v); check("R1 reset status", v, 8'h00);
    rd(1'b1, v); check("R1 reset data", v, 8'h00);
  endtask

  task automatic t_good8();
    logic [7:0] v;
    cfg_len7 = 0; cfg_par_en = 0; cfg_two_stop = 0;
    send(8'hA5, 0, 1, 1);
    rd(1'b0, v); check("R2 ready set", v, 8'h01);
    rd(1'b1, v); check("R2 data", v, 8'hA5);
    clear_all();
    rd(1'b0, v); check("R8 ready cleared", v, 8'h00);
  endtask

  task automatic t_seven();
    logic [7:0] v;
    cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 1;
    send(8'hD5, 0, 1, 1);
    rd(1'b0, v); check("R3 7-bit odd ok", v, 8'h01);
    rd(1'b1, v); check("R3 7-bit data", v, 8'h55);
    clear_all();
    cfg_len7 = 0;
  endtask

  task automatic t_parity();
    logic [7:0] v;
    cfg_par_en = 1; cfg_par_odd = 0;
    send(8'h3C, 1, 1, 1);
    rd(1'b0, v); check("R4 parity error", v, 8'h02);
    rd(1'b1, v); check("R6 data kept on error", v, 8'h3C);
  endtask

  task automatic t_stall();
    logic [7:0] v;
    send(8'h11, 0, 1, 1);
    rd(1'b0, v); check("R7 status held", v, 8'h02);
    rd(1'b1, v); check("R7 data held", v, 8'h3C);
  endtask

  task automatic t_clear_rule();
    logic [7:0] v;
    wr(3'b111);
    wr(3'b000);
    rd(1'b0, v); check("R8 unarmed write", v, 8'h02);
    wr(3'b000);
    rd(1'b0, v); check("R8 armed clear", v, 8'h00);
    cfg_par_en = 0;
  endtask

  task automatic t_frame();
    logic [7:0] v;
    send(8'h7E, 0, 0, 1);
    rd(1'b0, v); check("R5 framing error", v, 8'h04);
    rd(1'b1, v); check("R6 framed data kept", v, 8'h7E);
  endtask

  task automatic t_rx_off();
    logic [7:0] v;
    rx_en = 0;
    repeat (20) @(negedge clk);
    rd(1'b0, v); check("R9 flags kept", v, 8'h04);
    standby = 1;
    @(negedge clk);
    standby = 0;
    rd(1'b0, v); check("R1 standby clears", v, 8'h00);
    send(8'h22, 0, 1, 1);
    rd(1'b0, v); check("R9 no rx status", v, 8'h00);
    rd(1'b1, v); check("R9 no rx data", v, 8'h7E);
    rx_en = 1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_two_stop();
    logic [7:0] v;
    cfg_two_stop = 1;
    send(8'h99, 0, 1, 0);
    rd(1'b0, v); check("R5 second stop ignored", v, 8'h01);
    rd(1'b1, v); check("R5 two-stop data", v, 8'h99);
    clear_all();
    cfg_two_stop = 0;
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    @(negedge clk);
    hold(1'b0, 12);
    hold(1'b1, 3 * BIT);
    rd(1'b0, v); check("R10 glitch dropped", v, 8'h00);
    send(8'h5A, 0, 1, 1);
    rd(1'b0, v); check("R10 rx after glitch", v, 8'h01);
    rd(1'b1, v); check("R10 data after glitch", v, 8'h5A);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_good8();
    t_seven();
    t_parity();
    t_stall();
    t_clear_rule();
    t_frame();
    t_rx_off();
    t_two_stop();
    t_glitch();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule